// File: doc/BRIEF.md
# Stereo Event Coincidence Matcher

This block pairs up address events coming from a left and a right vision sensor. Each event has already been through an orientation-filter stage. It carries a column, a row, a polarity bit and the index of the orientation channel that produced it. The block looks for the left/right pair that belongs to the same scene point and emits the two addresses of that pair. A downstream stage uses them to compute a 3D position.

Each side keeps a small circular store of its recent unmatched events. Every entry is stamped with a free-running cycle counter. An arriving event is compared against every live entry of the opposite side. A candidate qualifies only when four tests pass together:
- its age lies within the programmable window;
- the polarity bits are equal;
- the rows differ by no more than the programmable tolerance, which is the epipolar test for rectified sensors;
- the orientation indices are equal.

When several entries qualify, the youngest one wins and is consumed. An arriving event that finds no partner is stored on its own side instead.

At most one event is handled per cycle. When both inputs present an event together, the left one goes first and the right input is stalled for a cycle.

Top module: `stereo_matcher`

## Requirements
- R1: Reset clears the match output to low and empties both event stores, so no event accepted before reset can pair with one accepted after it.
- R2: Two events qualify on time only when their acceptance cycles differ by at most `cfg_window` cycles, the bound included. The ages come from wrap-safe subtraction of counter stamps.
- R3: Two events qualify only when their polarity bits are equal.
- R4: Two events qualify only when the absolute row difference is at most `cfg_row_tol`. Column values play no part in matching.
- R5: Two events qualify only when their orientation-channel indices are equal.
- R6: A match is reported on `m_valid` for exactly one cycle, in the cycle after the edge that accepted the second event of the pair. It carries both columns and rows, plus the shared polarity and orientation.
- R7: When several stored entries qualify, the one accepted most recently is chosen.
- R8: A matched entry is removed from its store, and the arriving event that matched it is not stored. Neither can take part in a later match.
- R9: `r_ready` is low in any cycle where `l_valid` is high. A right event is accepted only on an edge where `r_valid` and `r_ready` are both high. As a result, in a same-cycle collision the left event is handled first and the right one one cycle later.
- R10: Each store holds its `DEPTH` most recent unmatched events. A new event overwrites the oldest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_window | input | TS_W | Largest allowed age difference in cycles |
| cfg_row_tol | input | Y_W | Largest allowed row difference |
| l_valid | input | 1 | Left event present |
| l_x | input | X_W | Left event column |
| l_y | input | Y_W | Left event row |
| l_pol | input | 1 | Left event polarity |
| l_ori | input | ORI_W | Left event orientation channel |
| r_valid | input | 1 | Right event present |
| r_x | input | X_W | Right event column |
| r_y | input | Y_W | Right event row |
| r_pol | input | 1 | Right event polarity |
| r_ori | input | ORI_W | Right event orientation channel |
| r_ready | output | 1 | Right event accepted this cycle when valid |
| m_valid | output | 1 | Matched pair present |
| m_l_x | output | X_W | Column of left member |
| m_l_y | output | Y_W | Row of left member |
| m_r_x | output | X_W | Column of right member |
| m_r_y | output | Y_W | Row of right member |
| m_pol | output | 1 | Shared polarity of the pair |
| m_ori | output | ORI_W | Shared orientation channel of the pair |

## Verification
The bench places pairs exactly at and one cycle beyond the time window and exactly at and one row beyond the tolerance. An off-by-one comparison therefore shows up as a missing or a surplus match.

It offers two equal candidates and then a second probe. A design that picks the oldest entry reports the wrong column; one that keeps consumed entries pairs an event twice.

A same-cycle collision checks that the right event is neither lost nor handled first. Nine left events fill a store of eight, so a design without overwrite matches an event that should be gone. A pair split by a reset checks that the reset empties the stores.

// File: rtl/stereo_pkg.sv
package stereo_pkg;

    parameter int X_W   = 7;
    parameter int Y_W   = 7;
    parameter int ORI_W = 3;

    typedef struct packed {
        logic [X_W-1:0]   x;
        logic [Y_W-1:0]   y;
        logic             pol;
        logic [ORI_W-1:0] ori;
    } evt_t;

    typedef struct packed {
        logic [X_W-1:0]   lx;
        logic [Y_W-1:0]   ly;
        logic [X_W-1:0]   rx;
        logic [Y_W-1:0]   ry;
        logic             pol;
        logic [ORI_W-1:0] ori;
    } pair_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_LEFT  = 2'd1,
        SRC_RIGHT = 2'd2
    } src_e;

    function automatic logic [Y_W-1:0] row_gap(input logic [Y_W-1:0] a,
                                               input logic [Y_W-1:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

    function automatic logic features_agree(input evt_t a, input evt_t b,
                                            input logic [Y_W-1:0] tol);
        return (a.pol == b.pol) && (a.ori == b.ori) && (row_gap(a.y, b.y) <= tol);
    endfunction

endpackage

// File: rtl/stamp_counter.sv
module stamp_counter #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TS_W-1:0] now
);

    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + 1'b1;
    end

endmodule

// File: rtl/side_buffer.sv
module side_buffer
    import stereo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TS_W  = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TS_W-1:0] now,
    input  logic [TS_W-1:0] window,
    input  logic [Y_W-1:0]  row_tol,
    input  evt_t            probe,
    input  logic            consume,
    input  logic            store,
    input  evt_t            store_evt,
    output logic            hit,
    output evt_t            hit_evt
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    evt_t            slot_evt   [DEPTH];
    logic [TS_W-1:0] slot_stamp [DEPTH];
    logic [TS_W-1:0] slot_age   [DEPTH];
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] fresh;
    logic [DEPTH-1:0] cand;
    logic [IDX_W-1:0] wr_ptr;
    logic [IDX_W-1:0] hit_idx;
    logic [TS_W-1:0]  best_age;

    // Per-entry age, freshness and candidate qualification.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign slot_age[g] = now - slot_stamp[g];
        assign fresh[g]    = live[g] && (slot_age[g] <= window);
        assign cand[g]     = fresh[g] && features_agree(slot_evt[g], probe, row_tol);
    end

    // Youngest qualifying entry wins; ages of live entries are distinct.
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        best_age = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (cand[i] && (!hit || slot_age[i] < best_age)) begin
                hit      = 1'b1;
                hit_idx  = IDX_W'(i);
                best_age = slot_age[i];
            end
        end
        hit_evt = slot_evt[hit_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live   <= '0;
            wr_ptr <= '0;
        end else begin
            live <= fresh;
            if (consume && hit)
                live[hit_idx] <= 1'b0;
            if (store) begin
                slot_evt[wr_ptr]   <= store_evt;
                slot_stamp[wr_ptr] <= now;
                live[wr_ptr]       <= 1'b1;
                wr_ptr             <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/stereo_matcher.sv
module stereo_matcher
    import stereo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TS_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TS_W-1:0]  cfg_window,
    input  logic [Y_W-1:0]   cfg_row_tol,
    input  logic             l_valid,
    input  logic [X_W-1:0]   l_x,
    input  logic [Y_W-1:0]   l_y,
    input  logic             l_pol,
    input  logic [ORI_W-1:0] l_ori,
    input  logic             r_valid,
    input  logic [X_W-1:0]   r_x,
    input  logic [Y_W-1:0]   r_y,
    input  logic             r_pol,
    input  logic [ORI_W-1:0] r_ori,
    output logic             r_ready,
    output logic             m_valid,
    output logic [X_W-1:0]   m_l_x,
    output logic [Y_W-1:0]   m_l_y,
    output logic [X_W-1:0]   m_r_x,
    output logic [Y_W-1:0]   m_r_y,
    output logic             m_pol,
    output logic [ORI_W-1:0] m_ori
);

    logic [TS_W-1:0] now;
    evt_t  l_evt, r_evt;
    evt_t  lbuf_hit_evt, rbuf_hit_evt;
    logic  lbuf_hit, rbuf_hit;
    src_e  src;
    pair_t pair_d, pair_q;
    logic  found;

    assign l_evt = '{x: l_x, y: l_y, pol: l_pol, ori: l_ori};
    assign r_evt = '{x: r_x, y: r_y, pol: r_pol, ori: r_ori};

    // Left has priority; the right input stalls while left is presented.
    assign r_ready = !l_valid;

    always_comb begin
        if (l_valid)      src = SRC_LEFT;
        else if (r_valid) src = SRC_RIGHT;
        else              src = SRC_NONE;
    end

    stamp_counter #(.TS_W(TS_W)) u_stamp (
        .clk (clk),
        .rst (rst),
        .now (now)
    );

    // Left store is probed by right events; right store by left events.
    side_buffer #(.DEPTH(DEPTH), .TS_W(TS_W)) u_lbuf (
        .clk       (clk),
        .rst       (rst),
        .now       (now),
        .window    (cfg_window),
        .row_tol   (cfg_row_tol),
        .probe     (r_evt),
        .consume   (src == SRC_RIGHT),
        .store     ((src == SRC_LEFT) && !rbuf_hit),
        .store_evt (l_evt),
        .hit       (lbuf_hit),
        .hit_evt   (lbuf_hit_evt)
    );

    side_buffer #(.DEPTH(DEPTH), .TS_W(TS_W)) u_rbuf (
        .clk       (clk),
        .rst       (rst),
        .now       (now),
        .window    (cfg_window),
        .row_tol   (cfg_row_tol),
        .probe     (l_evt),
        .consume   (src == SRC_LEFT),
        .store     ((src == SRC_RIGHT) && !lbuf_hit),
        .store_evt (r_evt),
        .hit       (rbuf_hit),
        .hit_evt   (rbuf_hit_evt)
    );

    always_comb begin
        found  = 1'b0;
        pair_d = '0;
        unique case (src)
            SRC_LEFT: begin
                found  = rbuf_hit;
                pair_d = '{lx: l_x, ly: l_y, rx: rbuf_hit_evt.x, ry: rbuf_hit_evt.y,
                           pol: l_pol, ori: l_ori};
            end
            SRC_RIGHT: begin
                found  = lbuf_hit;
                pair_d = '{lx: lbuf_hit_evt.x, ly: lbuf_hit_evt.y, rx: r_x, ry: r_y,
                           pol: r_pol, ori: r_ori};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_valid <= 1'b0;
            pair_q  <= '0;
        end else begin
            m_valid <= found;
            if (found) pair_q <= pair_d;
        end
    end

    assign m_l_x = pair_q.lx;
    assign m_l_y = pair_q.ly;
    assign m_r_x = pair_q.rx;
    assign m_r_y = pair_q.ry;
    assign m_pol = pair_q.pol;
    assign m_ori = pair_q.ori;

endmodule

// File: rtl/stereo_matcher_chk.sv
module stereo_matcher_chk
    import stereo_pkg::*;
#(
    parameter int TS_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [Y_W-1:0]   cfg_row_tol,
    input logic             l_valid,
    input logic             l_pol,
    input logic [ORI_W-1:0] l_ori,
    input logic             r_valid,
    input logic             r_ready,
    input logic             r_pol,
    input logic [ORI_W-1:0] r_ori,
    input logic             m_valid,
    input logic [Y_W-1:0]   m_l_y,
    input logic [Y_W-1:0]   m_r_y,
    input logic             m_pol,
    input logic [ORI_W-1:0] m_ori
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !m_valid);

    // R6
    match_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> $past(l_valid || (r_valid && r_ready)));

    // R4
    row_within_tol_chk: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> (row_gap(m_l_y, m_r_y) <= $past(cfg_row_tol)));

    // R3
    polarity_follows_chk: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> (m_pol == $past(l_valid ? l_pol : r_pol)));

    // R5
    orientation_follows_chk: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> (m_ori == $past(l_valid ? l_ori : r_ori)));

endmodule

bind stereo_matcher stereo_matcher_chk #(.TS_W(TS_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_row_tol (cfg_row_tol),
    .l_valid     (l_valid),
    .l_pol       (l_pol),
    .l_ori       (l_ori),
    .r_valid     (r_valid),
    .r_ready     (r_ready),
    .r_pol       (r_pol),
    .r_ori       (r_ori),
    .m_valid     (m_valid),
    .m_l_y       (m_l_y),
    .m_r_y       (m_r_y),
    .m_pol       (m_pol),
    .m_ori       (m_ori)
);

// File: tb/sim_stereo_matcher.sv
module sim_stereo_matcher;
    import stereo_pkg::*;

    localparam int TS_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [TS_W-1:0]  cfg_window = 16'd10;
    logic [Y_W-1:0]   cfg_row_tol = 7'd1;
    logic             l_valid = 1'b0, r_valid = 1'b0;
    logic [X_W-1:0]   l_x = '0, r_x = '0;
    logic [Y_W-1:0]   l_y = '0, r_y = '0;
    logic             l_pol = 1'b0, r_pol = 1'b0;
    logic [ORI_W-1:0] l_ori = '0, r_ori = '0;
    logic             r_ready, m_valid, m_pol;
    logic [X_W-1:0]   m_l_x, m_r_x;
    logic [Y_W-1:0]   m_l_y, m_r_y;
    logic [ORI_W-1:0] m_ori;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        pair_t p;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    stereo_matcher #(.DEPTH(8), .TS_W(TS_W)) u0 (
        .clk(clk), .rst(rst), .cfg_window(cfg_window), .cfg_row_tol(cfg_row_tol),
        .l_valid(l_valid), .l_x(l_x), .l_y(l_y), .l_pol(l_pol), .l_ori(l_ori),
        .r_valid(r_valid), .r_x(r_x), .r_y(r_y), .r_pol(r_pol), .r_ori(r_ori),
        .r_ready(r_ready), .m_valid(m_valid), .m_l_x(m_l_x), .m_l_y(m_l_y),
        .m_r_x(m_r_x), .m_r_y(m_r_y), .m_pol(m_pol), .m_ori(m_ori)
    );

    task automatic check(input string tag, input logic ok, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    // Driver side of the scoreboard: push the expected pair.
    task automatic expect_pair(input int lx, input int ly, input int rx, input int ry,
                               input int pol, input int ori, input string tag);
        exp_t e;
        e.p = '{lx: X_W'(lx), ly: Y_W'(ly), rx: X_W'(rx), ry: Y_W'(ry),
                pol: pol[0], ori: ORI_W'(ori)};
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: every reported match must be the next expected one.
    always @(negedge clk) begin
        if (!rst && m_valid) begin
            if (sb.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL unexpected match: actual L(%0d,%0d) R(%0d,%0d) expected none",
                         m_l_x, m_l_y, m_r_x, m_r_y);
            end else begin
                exp_t e;
                pair_t got;
                e = sb.pop_front();
                got = '{lx: m_l_x, ly: m_l_y, rx: m_r_x, ry: m_r_y, pol: m_pol, ori: m_ori};
                check(e.tag, got == e.p, int'(got), int'(e.p));
            end
        end
    end

    // Tasks are entered at a falling edge and leave at the next one.
    task automatic send_l(input int x, input int y, input int pol, input int ori);
        l_valid = 1'b1; l_x = X_W'(x); l_y = Y_W'(y); l_pol = pol[0]; l_ori = ORI_W'(ori);
        @(negedge clk);
        l_valid = 1'b0;
    endtask

    task automatic send_r(input int x, input int y, input int pol, input int ori);
        r_valid = 1'b1; r_x = X_W'(x); r_y = Y_W'(y); r_pol = pol[0]; r_ori = ORI_W'(ori);
        @(negedge clk);
        r_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drained(input string tag);
        idle(2);
        check({tag, " no further match"}, sb.size() == 0, sb.size(), 0);
        sb.delete();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        check("R1 m_valid low in reset", m_valid == 1'b0, m_valid, 0);
        check("R9 r_ready high when left idle", r_ready == 1'b1, r_ready, 1);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R6: basic pair and one-cycle latency
        expect_pair(5, 20, 9, 20, 1, 2, "R6 basic pair");
        send_l(5, 20, 1, 2);
        idle(2);
        send_r(9, 20, 1, 2);
        check("R6 m_valid one cycle after accept", m_valid == 1'b1, m_valid, 1);
        @(negedge clk);
        check("R6 m_valid single cycle", m_valid == 1'b0, m_valid, 0);
        drained("R6");

        // R2: difference equal to window matches
        do_reset();
        expect_pair(3, 10, 4, 10, 0, 1, "R2 at window bound");
        send_l(3, 10, 0, 1);
        idle(9);
        send_r(4, 10, 0, 1);
        drained("R2 bound");

        // R2: one cycle beyond the window
        do_reset();
        send_l(3, 10, 0, 1);
        idle(10);
        send_r(4, 10, 0, 1);
        drained("R2 beyond window");

        // R3: polarity mismatch
        do_reset();
        send_l(6, 12, 1, 3);
        send_r(6, 12, 0, 3);
        drained("R3 polarity mismatch");

        // R4: row gap equal to tolerance, columns differ
        do_reset();
        expect_pair(1, 20, 100, 21, 1, 0, "R4 gap at tolerance");
        send_l(1, 20, 1, 0);
        send_r(100, 21, 1, 0);
        drained("R4 at tolerance");

        // R4: row gap beyond tolerance
        do_reset();
        send_l(1, 20, 1, 0);
        send_r(1, 22, 1, 0);
        drained("R4 beyond tolerance");

        // R5: orientation mismatch
        do_reset();
        send_l(8, 33, 0, 4);
        send_r(8, 33, 0, 5);
        drained("R5 orientation mismatch");

        // R7: youngest candidate first, then the older one
        do_reset();
        expect_pair(2, 30, 7, 30, 1, 1, "R7 youngest chosen");
        expect_pair(1, 30, 8, 30, 1, 1, "R7 next youngest");
        send_l(1, 30, 1, 1);
        send_l(2, 30, 1, 1);
        send_r(7, 30, 1, 1);
        send_r(8, 30, 1, 1);
        drained("R7");

        // R8: consumed entries and matched arrivals are not reused
        do_reset();
        expect_pair(3, 40, 4, 40, 0, 2, "R8 first pair");
        expect_pair(6, 40, 5, 40, 0, 2, "R8 stored right pairs later");
        send_l(3, 40, 0, 2);
        send_r(4, 40, 0, 2);
        send_l(6, 40, 0, 2);
        send_r(5, 40, 0, 2);
        drained("R8");

        // R9: same-cycle collision, left first, right stalled one cycle
        do_reset();
        expect_pair(10, 50, 11, 50, 0, 1, "R9 collision pair");
        l_valid = 1'b1; l_x = 7'd10; l_y = 7'd50; l_pol = 1'b0; l_ori = 3'd1;
        r_valid = 1'b1; r_x = 7'd11; r_y = 7'd50; r_pol = 1'b0; r_ori = 3'd1;
        #1;
        check("R9 r_ready low with left present", r_ready == 1'b0, r_ready, 0);
        @(negedge clk);
        l_valid = 1'b0;
        #1;
        check("R9 r_ready high after left taken", r_ready == 1'b1, r_ready, 1);
        check("R9 no match while right stalled", m_valid == 1'b0, m_valid, 0);
        @(negedge clk);
        r_valid = 1'b0;
        check("R9 match after right accepted", m_valid == 1'b1, m_valid, 1);
        drained("R9");

        // R10: nine left events into a store of eight
        do_reset();
        for (int i = 0; i < 9; i++) send_l(i, 60 + 4 * i, 1, 6);
        send_r(20, 60, 1, 6);
        expect_pair(1, 64, 21, 64, 1, 6, "R10 second oldest kept");
        send_r(21, 64, 1, 6);
        drained("R10");

        // R1: reset between the two halves of a pair
        send_l(2, 70, 1, 3);
        do_reset();
        send_r(2, 70, 1, 3);
        drained("R1 reset empties stores");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule